// File: doc/BRIEF.md
# Buffered Interval Timer

This block is a 16-bit up-counter that produces a repeating interval. It advances only in clock cycles where the count-clock enable input is high. Software programs a control word and one compare value per channel through a small write port. The current count is always visible on a read-back output.

Compare values are not used directly. Each one is latched into a shadow buffer when counting starts and again each time the interval restarts. A write made while the timer is running therefore takes effect from the next interval.

Channel 0 sets the period: a match on it returns the counter to zero. Channel 1 only reports its match. Each channel drives a maskable one-cycle interrupt and a timer output pin. While a pin is enabled it toggles on every match of its channel. While it is disabled it drives a programmable static level.

Top module: `interval_timer`

Register map, selected by `wr_addr`:

| Address | Content |
|---|---|
| 0 | Control word |
| 1 | Channel-0 compare value |
| 2 | Channel-1 compare value |

Control word fields:

| Bit(s) | Field | Meaning |
|---|---|---|
| 0 | run | Count enable |
| 3:1 | mode | 000 selects interval mode |
| 4 | oe0 | Output 0 enable |
| 5 | lvl0 | Output 0 level |
| 6 | msk0 | Interrupt 0 mask |
| 7 | oe1 | Output 1 enable |
| 8 | lvl1 | Output 1 level |
| 9 | msk1 | Interrupt 1 mask |

## Requirements
- R1: After reset, `count_o` is 0, both interrupts are low and both timer outputs are low.
- R2: While run is 1 and mode is 000, each count enable advances `count_o` by one. A count enable that arrives while the count equals the channel-0 buffer returns it to 0. The interval is therefore (D0 + 1) count enables, where D0 is the channel-0 compare value.
- R3: `irq_o[0]` is high for exactly the one clock after each count enable that restarts the interval, unless msk0 (bit 6) is 1, in which case it stays low.
- R4: `irq_o[1]` is high for the one clock after each count enable taken while the count equals the channel-1 buffer, unless msk1 (bit 9) is 1. A channel-1 match does not disturb counting.
- R5: Compare values are latched into their buffers in the first clock after counting starts and at every channel-0 restart. A compare write made mid-interval takes effect only from the next interval.
- R6: While oeN is 0, `tout_o[N]` equals lvlN (output 0: oe0 bit 4, lvl0 bit 5; output 1: oe1 bit 7, lvl1 bit 8).
- R7: While oeN is 1, `tout_o[N]` takes the value of lvlN when counting starts and toggles on every match of channel N.
- R8: Clearing run returns `count_o` to 0 and holds it there, whatever the count enable does.
- R9: A mode value other than 000 holds the counter idle at 0, even with run set.
- R10: In a clock cycle where `tick_en` is low, `count_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control word, 1 channel-0 compare, 2 channel-1 compare |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current count |
| irq_o | output | 2 | Per-channel match interrupts, one-cycle pulses |
| tout_o | output | 2 | Timer output pins |

## Verification
A corrupted shadow buffer shows up within one interval. The period then differs from D0 + 1, or a write made mid-interval takes hold early. This is visible both on `count_o` and in the number of `irq_o[0]` pulses.

A stale toggle bit appears on `tout_o` in the first clock after counting starts, or after the next match. A bad mask or gating term shows up as a missing or extra interrupt pulse in the clock after the offending count enable.

// File: rtl/itm_pkg.sv
package itm_pkg;
   // Control word layout
   localparam int RUN_BIT   = 0;
   localparam int MODE_LSB  = 1;
   localparam int MODE_W    = 3;
   localparam int CH_BASE   = MODE_LSB + MODE_W;
   localparam int CH_STRIDE = 3;
   localparam int OE_OFS    = 0;
   localparam int LVL_OFS   = 1;
   localparam int MSK_OFS   = 2;
   // Mode code that selects interval operation
   localparam logic [MODE_W-1:0] MODE_INTERVAL = '0;

   function automatic int ctrl_bits(input int nch);
      return CH_BASE + CH_STRIDE * nch;
   endfunction
endpackage

// File: rtl/itm_regs.sv
module itm_regs #(
   parameter int DATA_W = 16,
   parameter int NCH    = 2,
   parameter int ADDR_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [DATA_W-1:0]        ctrl_q,
   output logic [NCH-1:0][DATA_W-1:0] cmp_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en && wr_addr == '0) begin
         ctrl_q <= wr_data;
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_cmp
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp_q[i] <= '0;
         end else if (wr_en && wr_addr == MY_ADDR) begin
            cmp_q[i] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/itm_counter.sv
module itm_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             tick,
   input  logic             wrap,
   output logic             start,
   output logic [CNT_W-1:0] cnt
);
   logic act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= active;
   end

   assign start = active & ~act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!active || start) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= wrap ? '0 : cnt + 1'b1;
      end
   end

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && tick && !start && !wrap) |=> (cnt == $past(cnt) + 1'b1));
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !tick && !start) |=> $stable(cnt));
   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && $past(!active)) |-> (cnt == '0));
endmodule

// File: rtl/itm_channel.sv
module itm_channel #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             start,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [CNT_W-1:0] count,
   input  logic             oe,
   input  logic             lvl,
   input  logic             mask,
   output logic             hit,
   output logic             irq,
   output logic             tout
);
   logic [CNT_W-1:0] buf_q;
   logic             tgl_q;

   assign hit = active & tick & ~start & (count == buf_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         tgl_q <= 1'b0;
         irq   <= 1'b0;
      end else begin
         if (load)       buf_q <= cmp_val;
         if (start)      tgl_q <= lvl;
         else if (hit)   tgl_q <= ~tgl_q;
         irq <= hit & ~mask;
      end
   end

   assign tout = oe ? tgl_q : lvl;

   p_irq_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(active && tick && !mask));
   p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && oe) |=> (tout != $past(tout)));
   p_start_lvl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && oe && $stable(lvl)) |=> (tout == lvl));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
   parameter int CNT_W  = 16,
   parameter int NCH    = 2,
   parameter int ADDR_W = $clog2(NCH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  count_o,
   output logic [NCH-1:0]    irq_o,
   output logic [NCH-1:0]    tout_o
);
   import itm_pkg::*;

   localparam int CTRL_W = ctrl_bits(NCH);

   if (NCH < 1) begin : g_bad_nch
      $error("interval_timer: NCH must be at least 1");
   end
   if (CTRL_W > CNT_W) begin : g_bad_w
      $error("interval_timer: control word does not fit in CNT_W");
   end
   if ((1 << ADDR_W) < NCH + 1) begin : g_bad_a
      $error("interval_timer: ADDR_W too small");
   end

   logic [CNT_W-1:0]            ctrl_q;
   logic [NCH-1:0][CNT_W-1:0]   cmp_q;
   logic                        active, start, load;
   logic [NCH-1:0]              hit;

   itm_regs #(.DATA_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ctrl_q(ctrl_q), .cmp_q(cmp_q)
   );

   assign active = ctrl_q[RUN_BIT]
                 & (ctrl_q[MODE_LSB +: MODE_W] == MODE_INTERVAL);
   assign load   = start | hit[0];

   itm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .active(active), .tick(tick_en),
      .wrap(hit[0]), .start(start), .cnt(count_o)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int B = CH_BASE + CH_STRIDE * i;
      itm_channel #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .active(active), .start(start),
         .tick(tick_en), .load(load), .cmp_val(cmp_q[i]), .count(count_o),
         .oe(ctrl_q[B + OE_OFS]), .lvl(ctrl_q[B + LVL_OFS]),
         .mask(ctrl_q[B + MSK_OFS]),
         .hit(hit[i]), .irq(irq_o[i]), .tout(tout_o[i])
      );
   end

   p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit[0] |=> (count_o == '0));
   p_mode_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[MODE_LSB +: MODE_W] != MODE_INTERVAL) |-> !(|hit));
   p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[0] && !$past(hit[0])) |-> 1'b0);
endmodule

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] count_o;
   logic [1:0]  irq_o, tout_o;

   int n_run = 0, n_fail = 0;
   int irq0_tot = 0, irq1_tot = 0;

   always #10 clk = ~clk;

   interval_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .count_o(count_o),
      .irq_o(irq_o), .tout_o(tout_o)
   );

   always @(negedge clk) begin
      if (irq_o[0]) irq0_tot++;
      if (irq_o[1]) irq1_tot++;
   end

   // d0, d1, ticks, expected irq0 pulses, irq1 pulses, final count
   localparam int VEC [0:5][0:5] = '{
      '{4, 2, 12, 2, 2, 2},
      '{0, 0,  5, 5, 5, 0},
      '{9, 12, 25, 2, 0, 5},
      '{3, 3,  8, 2, 2, 0},
      '{7, 0,  3, 0, 1, 3},
      '{2, 1,  7, 2, 2, 1}
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input int d);
      wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
   endtask

   function automatic int ctrl(input bit run, input int mode,
                               input bit oe0, input bit lv0, input bit m0,
                               input bit oe1, input bit lv1, input bit m1);
      return int'(run) | (mode << 1) | (int'(oe0) << 4) | (int'(lv0) << 5)
           | (int'(m0) << 6) | (int'(oe1) << 7) | (int'(lv1) << 8) | (int'(m1) << 9);
   endfunction

   task automatic ticks(input int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic arm(input int d0, input int d1, input int c);
      wr(2'd0, 0);
      wr(2'd1, d0);
      wr(2'd2, d1);
      wr(2'd0, c);
      @(negedge clk);   // start cycle
   endtask

   initial begin
      int s0, s1;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(count_o == 16'd0, "R1 count", count_o, 0);
      check(irq_o == 2'b00, "R1 irq", irq_o, 0);
      check(tout_o == 2'b00, "R1 tout", tout_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table: R2 interval, R3/R4 interrupts
      for (int v = 0; v < 6; v++) begin
         arm(VEC[v][0], VEC[v][1], ctrl(1, 0, 0, 0, 0, 0, 0, 0));
         s0 = irq0_tot; s1 = irq1_tot;
         ticks(VEC[v][2]);
         repeat (2) @(negedge clk);
         check(count_o == 16'(VEC[v][5]), "R2 count", count_o, VEC[v][5]);
         check(irq0_tot - s0 == VEC[v][3], "R3 irq0 pulses", irq0_tot - s0, VEC[v][3]);
         check(irq1_tot - s1 == VEC[v][4], "R4 irq1 pulses", irq1_tot - s1, VEC[v][4]);
      end

      // R3/R4 masks
      arm(1, 0, ctrl(1, 0, 0, 0, 1, 0, 0, 1));
      s0 = irq0_tot; s1 = irq1_tot;
      ticks(4);
      repeat (2) @(negedge clk);
      check(irq0_tot == s0, "R3 masked irq0", irq0_tot - s0, 0);
      check(irq1_tot == s1, "R4 masked irq1", irq1_tot - s1, 0);
      check(count_o == 16'd0, "R3 masked count wraps", count_o, 0);

      // R5 buffered compare
      arm(5, 40, ctrl(1, 0, 0, 0, 0, 0, 0, 0));
      s0 = irq0_tot;
      ticks(2);
      wr(2'd1, 1);
      ticks(4);
      @(negedge clk);
      check(count_o == 16'd0, "R5 old period kept", count_o, 0);
      ticks(3);
      repeat (2) @(negedge clk);
      check(count_o == 16'd1, "R5 new period", count_o, 1);
      check(irq0_tot - s0 == 2, "R5 irq0", irq0_tot - s0, 2);

      // R10 hold without tick
      arm(9, 0, ctrl(1, 0, 0, 0, 0, 0, 0, 0));
      ticks(3);
      repeat (5) @(negedge clk);
      check(count_o == 16'd3, "R10 hold", count_o, 3);

      // R8 stop clears and holds
      wr(2'd0, ctrl(0, 0, 0, 0, 0, 0, 0, 0));
      check(count_o == 16'd0, "R8 cleared", count_o, 0);
      ticks(4);
      check(count_o == 16'd0, "R8 held", count_o, 0);

      // R9 non-interval mode idle
      wr(2'd0, ctrl(1, 3, 0, 0, 0, 0, 0, 0));
      @(negedge clk);
      ticks(4);
      check(count_o == 16'd0, "R9 idle", count_o, 0);

      // R6 disabled outputs drive level
      wr(2'd0, ctrl(0, 0, 0, 1, 0, 0, 0, 0));
      check(tout_o == 2'b01, "R6 levels a", tout_o, 1);
      wr(2'd0, ctrl(0, 0, 0, 0, 0, 0, 1, 0));
      check(tout_o == 2'b10, "R6 levels b", tout_o, 2);

      // R7 enabled outputs toggle
      arm(3, 1, ctrl(1, 0, 1, 0, 0, 1, 1, 0));
      check(tout_o == 2'b10, "R7 start level", tout_o, 2);
      ticks(2);
      check(tout_o == 2'b00, "R7 ch1 toggle", tout_o, 0);
      ticks(2);
      check(tout_o == 2'b01, "R7 ch0 toggle", tout_o, 1);
      ticks(4);
      check(tout_o == 2'b10, "R7 second interval", tout_o, 2);
      // R6 while running with output disabled
      wr(2'd0, ctrl(1, 0, 0, 1, 0, 1, 1, 0));
      check(tout_o[0] == 1'b1, "R6 running disabled", tout_o[0], 1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule